// File: doc/BRIEF.md
# System Control Register File

This block holds the privileged control registers of a processor core: translation-entry staging registers, exception bookkeeping, interrupt status and cause, configuration words and debug state. Software reaches them through a move-to port (register number, select, data, strobe) and a move-from port (register number, select, read data). Each register has its own set of writable bits. Bits outside that set keep their stored value, so read-only flags survive a software write.

Besides storage, the block derives the core's operating-mode flags (user, exception level, error level, debug) from Status and Debug writes. It raises or drops a hard-interrupt request when software toggles the global enable. It also emits a one-cycle flush request whenever an EntryHi write changes the address-space identifier. External interrupt lines are sampled into the Cause register. The random-replacement index is supplied from outside and read back as register 1.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset every stored register reads zero except Config (register 16, select 0), which reads the CFG0_RST parameter; hard_irq, tlb_flush and all four mode flags are low.
- R2: An access with a nonzero select to any register other than 16 and 28 writes nothing, leaves the mode flags unchanged, and reads zero.
- R3: A write to Index (register 0) keeps bit 31 and takes only data bits 3:0. A write to Wired (register 6) stores only data bits 3:0.
- R4: EntryLo0/EntryLo1 (registers 2 and 3) store data AND 0x3FFFFFFF. PageMask (register 5) stores data AND 0x01FFE000. WatchHi (register 19) stores data AND 0x40FF0FF8.
- R5: A write to Context (register 4) keeps bits 31:23 and takes data bits 22:4; bits 3:0 read zero.
- R6: EntryHi (register 10) stores data AND 0xFFFFE0FF. tlb_flush is high for exactly the cycle after a write whose bits 7:0 differ from the stored bits 7:0, and stays low otherwise.
- R7: Status (register 12) stores data AND 0xFA78FF01. On each Status write, user_mode, erl_mode and exl_mode take data bits 4, 2 and 1, and they hold between Status writes.
- R8: A Status write that takes IE (bit 0) from 0 to 1 sets hard_irq when all of the following hold: written bits 1 and 2 are clear, debug_mode is low, and (written bits 15:8 AND Cause bits 15:8) is nonzero. Any other IE-raising write leaves hard_irq low.
- R9: A Status write that takes IE from 1 to 0 clears hard_irq. hard_irq otherwise holds its value, including across a write that keeps IE at 1.
- R10: A Cause (register 13) write changes only bits 9:8. Cause bits 15:10 show hw_irq[5:0] as registered one cycle earlier, and the R8 qualification uses that registered copy.
- R11: A Status read ORs user_mode into bit 4. Debug (register 23) stores data AND 0x13300120 and keeps its other bits. debug_mode takes data bit 30 on each Debug write, and a Debug read ORs debug_mode into bit 30.
- R12: LLAddr (register 17) stores the full written word, and a read returns it shifted right by 4.
- R13: Register 1 reads random_idx zero-extended. Register 15 reads PRID_VAL and register 16 select 1 reads CFG1_VAL, and writes to either have no effect. Unimplemented register numbers read zero.
- R14: Config (register 16, select 0) takes only data bit 0 from a write. TagLo (register 28, select 0) stores data AND 0xFFFFFCF6. EPC, Count, Compare, WatchLo, DEPC, ErrorEPC and DESAVE (14, 9, 11, 18, 24, 30, 31) store the full word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Move-to strobe |
| wr_reg | input | 5 | Move-to register number |
| wr_sel | input | 3 | Move-to select |
| wr_data | input | 32 | Move-to data |
| rd_reg | input | 5 | Move-from register number |
| rd_sel | input | 3 | Move-from select |
| rd_data | output | 32 | Move-from data (combinational) |
| hw_irq | input | 6 | External interrupt pending lines |
| random_idx | input | 4 | Replacement index shown as register 1 |
| hard_irq | output | 1 | Hard-interrupt request |
| user_mode | output | 1 | User-mode flag |
| exl_mode | output | 1 | Exception-level flag |
| erl_mode | output | 1 | Error-level flag |
| debug_mode | output | 1 | Debug-mode flag |
| tlb_flush | output | 1 | One-cycle translation flush request |

## Verification
An external interrupt line can rise in the same cycle as a Status write that enables interrupts. The sampling of hw_irq into Cause and the interrupt qualification then meet on one clock edge. The bench drives both on one edge and expects hard_irq to stay low, because the qualification sees the Cause copy from before that edge. It then reads Cause to confirm that the line has been captured, and toggles IE to show that the request now rises.

// File: rtl/sysctl_pkg.sv
// Shared constants and the per-slot register description for the
// system control register file. Assumes a 32-bit data path; every
// mask below is written for that width.
package sysctl_pkg;

    localparam int DW     = 32;
    localparam int RNUM_W = 5;
    localparam int SEL_W  = 3;
    localparam int HWI_W  = 6;
    localparam int HWI_LSB = 10;
    localparam int NSLOT  = 21;

    // Register numbers with behaviour beyond masked storage
    localparam logic [RNUM_W-1:0] REG_RANDOM = 5'd1;
    localparam logic [RNUM_W-1:0] REG_EHI    = 5'd10;
    localparam logic [RNUM_W-1:0] REG_STATUS = 5'd12;
    localparam logic [RNUM_W-1:0] REG_CAUSE  = 5'd13;
    localparam logic [RNUM_W-1:0] REG_PRID   = 5'd15;
    localparam logic [RNUM_W-1:0] REG_CONFIG = 5'd16;
    localparam logic [RNUM_W-1:0] REG_LLADDR = 5'd17;
    localparam logic [RNUM_W-1:0] REG_DEBUG  = 5'd23;
    localparam logic [RNUM_W-1:0] REG_TAG    = 5'd28;

    // Slot positions of registers the rest of the block looks into
    localparam int SL_EHI    = 7;
    localparam int SL_STATUS = 9;
    localparam int SL_CAUSE  = 10;
    localparam int SL_CFG0   = 12;
    localparam int SL_LLADDR = 13;
    localparam int SL_DEBUG  = 16;

    // Flag bit positions
    localparam int UM_BIT  = 4;
    localparam int ERL_BIT = 2;
    localparam int EXL_BIT = 1;
    localparam int IE_BIT  = 0;
    localparam int DM_BIT  = 30;
    localparam int LL_SHIFT = 4;

    // Register number stored in each slot (all slots use select 0)
    function automatic logic [RNUM_W-1:0] slot_reg(input int idx);
        case (idx)
            0:  slot_reg = 5'd0;
            1:  slot_reg = 5'd2;
            2:  slot_reg = 5'd3;
            3:  slot_reg = 5'd4;
            4:  slot_reg = 5'd5;
            5:  slot_reg = 5'd6;
            6:  slot_reg = 5'd9;
            7:  slot_reg = 5'd10;
            8:  slot_reg = 5'd11;
            9:  slot_reg = 5'd12;
            10: slot_reg = 5'd13;
            11: slot_reg = 5'd14;
            12: slot_reg = 5'd16;
            13: slot_reg = 5'd17;
            14: slot_reg = 5'd18;
            15: slot_reg = 5'd19;
            16: slot_reg = 5'd23;
            17: slot_reg = 5'd24;
            18: slot_reg = 5'd28;
            19: slot_reg = 5'd30;
            default: slot_reg = 5'd31;
        endcase
    endfunction

    // Bits a write may change in each slot; the rest are preserved
    function automatic logic [DW-1:0] slot_take(input int idx);
        case (idx)
            0:  slot_take = 32'h0000_000F;
            1:  slot_take = 32'h3FFF_FFFF;
            2:  slot_take = 32'h3FFF_FFFF;
            3:  slot_take = 32'h007F_FFF0;
            4:  slot_take = 32'h01FF_E000;
            5:  slot_take = 32'h0000_000F;
            7:  slot_take = 32'hFFFF_E0FF;
            9:  slot_take = 32'hFA78_FF01;
            10: slot_take = 32'h0000_0300;
            12: slot_take = 32'h0000_0001;
            15: slot_take = 32'h40FF_0FF8;
            16: slot_take = 32'h1330_0120;
            18: slot_take = 32'hFFFF_FCF6;
            default: slot_take = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_wdecode.sv
// Move-to decoder: turns register number and select into one write
// strobe per storage slot. Assumes every slot lives at select 0, so a
// nonzero select never produces a strobe.
module sysctl_wdecode
    import sysctl_pkg::*;
(
    input  logic              wr_en,
    input  logic [RNUM_W-1:0] wr_reg,
    input  logic [SEL_W-1:0]  wr_sel,
    output logic [NSLOT-1:0]  slot_we
);

    logic sel_zero;

    // Only select 0 reaches any stored register
    assign sel_zero = (wr_sel == '0);

    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_dec
        // One strobe per slot when the register number matches
        assign slot_we[gi] = wr_en && sel_zero && (wr_reg == slot_reg(gi));
    end

endmodule

// File: rtl/sysctl_field_reg.sv
// One masked control register: on a write, bits set in TAKE come from
// the data and all other bits keep their stored value. Reset loads RST.
module sysctl_field_reg #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAKE = '1,
    parameter logic [W-1:0] RST  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Masked merge of new data into the stored word
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST;
        else if (we)
            q <= (q & ~TAKE) | (d & TAKE);
    end

endmodule

// File: rtl/sysctl_mode_ctrl.sv
// Mode flags, hard-interrupt request and translation flush request.
// Assumes the caller passes the pre-write Status IE bit, the pre-write
// EntryHi identifier and the registered Cause interrupt byte.
module sysctl_mode_ctrl
    import sysctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        st_we,
    input  logic        dbg_we,
    input  logic        ehi_we,
    input  logic [15:0] wd_low,
    input  logic        wd_dm,
    input  logic        ie_old,
    input  logic [7:0]  asid_old,
    input  logic [7:0]  cause_im,
    output logic        user_mode,
    output logic        exl_mode,
    output logic        erl_mode,
    output logic        debug_mode,
    output logic        hard_irq,
    output logic        tlb_flush
);

    logic       ie_new;
    logic       irq_pend;
    logic       irq_raise;
    logic       irq_drop;

    // Qualification terms for an interrupt-enable change
    always_comb begin
        ie_new    = wd_low[IE_BIT];
        irq_pend  = |(wd_low[15:8] & cause_im);
        irq_raise = ie_new && !ie_old && !wd_low[EXL_BIT] && !wd_low[ERL_BIT]
                    && !debug_mode && irq_pend;
        irq_drop  = !ie_new && ie_old;
    end

    // Mode flags follow Status and Debug writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            user_mode  <= 1'b0;
            exl_mode   <= 1'b0;
            erl_mode   <= 1'b0;
            debug_mode <= 1'b0;
        end else begin
            if (st_we) begin
                user_mode <= wd_low[UM_BIT];
                exl_mode  <= wd_low[EXL_BIT];
                erl_mode  <= wd_low[ERL_BIT];
            end
            if (dbg_we)
                debug_mode <= wd_dm;
        end
    end

    // Hard-interrupt request set or cleared only by Status writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            hard_irq <= 1'b0;
        else if (st_we && irq_raise)
            hard_irq <= 1'b1;
        else if (st_we && irq_drop)
            hard_irq <= 1'b0;
    end

    // One-cycle flush pulse on an identifier change
    always_ff @(posedge clk) begin
        if (!rst_n)
            tlb_flush <= 1'b0;
        else
            tlb_flush <= ehi_we && (wd_low[7:0] != asid_old);
    end

endmodule

// File: rtl/sysctl_rd_mux.sv
// Move-from multiplexer: picks the stored slot for a select-0 access,
// overlays live flags and constant registers, and returns zero for
// anything unimplemented or any invalid select.
module sysctl_rd_mux
    import sysctl_pkg::*;
#(
    parameter int          RAND_W   = 4,
    parameter logic [31:0] PRID_VAL = 32'h0001_8000,
    parameter logic [31:0] CFG1_VAL = 32'h1E19_0C8A
) (
    input  logic [RNUM_W-1:0]        rd_reg,
    input  logic [SEL_W-1:0]         rd_sel,
    input  logic [NSLOT-1:0][DW-1:0] slot_q,
    input  logic [RAND_W-1:0]        random_idx,
    input  logic [HWI_W-1:0]         hw_q,
    input  logic                     um,
    input  logic                     dm,
    output logic [DW-1:0]            rd_data
);

    // Read selection with per-register overlays
    always_comb begin
        rd_data = '0;
        if (rd_sel == '0) begin
            for (int i = 0; i < NSLOT; i++)
                if (rd_reg == slot_reg(i))
                    rd_data = slot_q[i];
            case (rd_reg)
                REG_RANDOM: rd_data = {{(DW-RAND_W){1'b0}}, random_idx};
                REG_PRID:   rd_data = PRID_VAL;
                REG_STATUS: rd_data = slot_q[SL_STATUS] | (DW'(um) << UM_BIT);
                REG_CAUSE:  rd_data = slot_q[SL_CAUSE] | (DW'(hw_q) << HWI_LSB);
                REG_LLADDR: rd_data = slot_q[SL_LLADDR] >> LL_SHIFT;
                REG_DEBUG:  rd_data = slot_q[SL_DEBUG] | (DW'(dm) << DM_BIT);
                default:    ;
            endcase
        end else if (rd_reg == REG_CONFIG && rd_sel == SEL_W'(1)) begin
            rd_data = CFG1_VAL;
        end
    end

endmodule

// File: rtl/sysctl_regfile.sv
// Top of the system control register file. Instantiates one masked
// register per storage slot, samples the external interrupt lines,
// and ties in the mode controller and the read multiplexer.
// Assumes writes and reads are single-cycle and never stalled.
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int          RAND_W   = 4,
    parameter logic [31:0] PRID_VAL = 32'h0001_8000,
    parameter logic [31:0] CFG1_VAL = 32'h1E19_0C8A,
    parameter logic [31:0] CFG0_RST = 32'h8000_8082
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RNUM_W-1:0] wr_reg,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DW-1:0]     wr_data,
    input  logic [RNUM_W-1:0] rd_reg,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DW-1:0]     rd_data,
    input  logic [HWI_W-1:0]  hw_irq,
    input  logic [RAND_W-1:0] random_idx,
    output logic              hard_irq,
    output logic              user_mode,
    output logic              exl_mode,
    output logic              erl_mode,
    output logic              debug_mode,
    output logic              tlb_flush
);

    logic [NSLOT-1:0]         slot_we;
    logic [NSLOT-1:0][DW-1:0] slot_q;
    logic [HWI_W-1:0]         hw_q;
    logic [7:0]               cause_im;

    sysctl_wdecode u_dec (
        .wr_en   (wr_en),
        .wr_reg  (wr_reg),
        .wr_sel  (wr_sel),
        .slot_we (slot_we)
    );

    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
        // Config is the only slot with a nonzero reset word
        localparam logic [DW-1:0] RST_V = (gi == SL_CFG0) ? CFG0_RST : '0;
        sysctl_field_reg #(
            .W    (DW),
            .TAKE (slot_take(gi)),
            .RST  (RST_V)
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (slot_we[gi]),
            .d     (wr_data),
            .q     (slot_q[gi])
        );
    end

    // Sample external interrupt lines into the Cause pending field
    always_ff @(posedge clk) begin
        if (!rst_n)
            hw_q <= '0;
        else
            hw_q <= hw_irq;
    end

    // Cause interrupt byte as seen by the qualification logic
    assign cause_im = {hw_q, slot_q[SL_CAUSE][9:8]};

    sysctl_mode_ctrl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_we      (slot_we[SL_STATUS]),
        .dbg_we     (slot_we[SL_DEBUG]),
        .ehi_we     (slot_we[SL_EHI]),
        .wd_low     (wr_data[15:0]),
        .wd_dm      (wr_data[DM_BIT]),
        .ie_old     (slot_q[SL_STATUS][IE_BIT]),
        .asid_old   (slot_q[SL_EHI][7:0]),
        .cause_im   (cause_im),
        .user_mode  (user_mode),
        .exl_mode   (exl_mode),
        .erl_mode   (erl_mode),
        .debug_mode (debug_mode),
        .hard_irq   (hard_irq),
        .tlb_flush  (tlb_flush)
    );

    sysctl_rd_mux #(
        .RAND_W   (RAND_W),
        .PRID_VAL (PRID_VAL),
        .CFG1_VAL (CFG1_VAL)
    ) u_rd (
        .rd_reg     (rd_reg),
        .rd_sel     (rd_sel),
        .slot_q     (slot_q),
        .random_idx (random_idx),
        .hw_q       (hw_q),
        .um         (user_mode),
        .dm         (debug_mode),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/sysctl_regfile_chk.sv
// Port-level protocol checks for the system control register file,
// bound to every instance of the top module.
module sysctl_regfile_chk
    import sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [RNUM_W-1:0] wr_reg,
    input logic [SEL_W-1:0]  wr_sel,
    input logic [DW-1:0]     wr_data,
    input logic              hard_irq,
    input logic              user_mode,
    input logic              exl_mode,
    input logic              erl_mode,
    input logic              debug_mode,
    input logic              tlb_flush
);

    logic st_wr;
    logic ehi_wr;
    logic bad_sel;

    // Port-side view of the accesses the properties refer to
    assign st_wr   = wr_en && wr_sel == '0 && wr_reg == REG_STATUS;
    assign ehi_wr  = wr_en && wr_sel == '0 && wr_reg == REG_EHI;
    assign bad_sel = wr_en && wr_sel != '0 && wr_reg != REG_CONFIG && wr_reg != REG_TAG;

    p_flush_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush |-> $past(ehi_wr));

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hard_irq) |-> $past(st_wr && wr_data[IE_BIT]));

    p_irq_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hard_irq) |-> (!exl_mode && !erl_mode && !debug_mode));

    p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hard_irq) |-> $past(st_wr && !wr_data[IE_BIT]));

    p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!st_wr) |-> $stable({user_mode, exl_mode, erl_mode}));

    p_bad_sel_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bad_sel |=> (!tlb_flush && $stable({user_mode, exl_mode, erl_mode, debug_mode, hard_irq})));

endmodule

bind sysctl_regfile sysctl_regfile_chk chk_i (.*);

// File: tb/sysctl_regfile_tb_top.sv
// Self-checking bench: a table of write/readback vectors, then directed
// sequences for reset, interrupt qualification, flags and corner cases.
module sysctl_regfile_tb_top;

    localparam logic [31:0] PRID_E = 32'h0001_8000;
    localparam logic [31:0] CFG1_E = 32'h1E19_0C8A;
    localparam logic [31:0] CFG0_E = 32'h8000_8082;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [4:0]  wr_reg;
    logic [2:0]  wr_sel;
    logic [31:0] wr_data;
    logic [4:0]  rd_reg;
    logic [2:0]  rd_sel;
    logic [31:0] rd_data;
    logic [5:0]  hw_irq;
    logic [3:0]  random_idx;
    logic        hard_irq, user_mode, exl_mode, erl_mode, debug_mode, tlb_flush;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    sysctl_regfile dut_i (.*);

    // {req[3:0], reg[4:0], sel[2:0], wdata[31:0], expect[31:0]}
    localparam int NV = 14;
    localparam logic [75:0] VEC [NV] = '{
        {4'd3,  5'd0,  3'd0, 32'hFFFF_FFFF, 32'h0000_000F},  // R3 Index
        {4'd3,  5'd6,  3'd0, 32'hFFFF_FFF5, 32'h0000_0005},  // R3 Wired
        {4'd4,  5'd2,  3'd0, 32'hFFFF_FFFF, 32'h3FFF_FFFF},  // R4 EntryLo0
        {4'd4,  5'd3,  3'd0, 32'h1234_5678, 32'h1234_5678},  // R4 EntryLo1
        {4'd4,  5'd5,  3'd0, 32'hFFFF_FFFF, 32'h01FF_E000},  // R4 PageMask
        {4'd4,  5'd19, 3'd0, 32'hFFFF_FFFF, 32'h40FF_0FF8},  // R4 WatchHi
        {4'd5,  5'd4,  3'd0, 32'hFFFF_FFFF, 32'h007F_FFF0},  // R5 Context
        {4'd6,  5'd10, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_E0FF},  // R6 EntryHi
        {4'd10, 5'd13, 3'd0, 32'hFFFF_FFFF, 32'h0000_0300},  // R10 Cause
        {4'd12, 5'd17, 3'd0, 32'h1234_5678, 32'h0123_4567},  // R12 LLAddr
        {4'd14, 5'd16, 3'd0, 32'hFFFF_FFFF, 32'h8000_8083},  // R14 Config
        {4'd14, 5'd28, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FCF6},  // R14 TagLo
        {4'd14, 5'd14, 3'd0, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R14 EPC
        {4'd14, 5'd31, 3'd0, 32'hA5A5_0F0F, 32'hA5A5_0F0F}   // R14 DESAVE
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one move-to access for one clock; returns at the next negedge
    task automatic wr(input logic [4:0] r, input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_reg = r; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Combinational move-from read
    task automatic rd(input logic [4:0] r, input logic [2:0] s, output logic [31:0] d);
        rd_reg = r; rd_sel = s;
        #1;
        d = rd_data;
    endtask

    // Watchdog: counts as a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; wr_en = 1'b0; wr_reg = '0; wr_sel = '0; wr_data = '0;
        rd_reg = '0; rd_sel = '0; hw_irq = '0; random_idx = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'd12, 3'd0, v); check("R1 status", v, 32'h0);
        rd(5'd14, 3'd0, v); check("R1 epc", v, 32'h0);
        rd(5'd16, 3'd0, v); check("R1 config", v, CFG0_E);
        check("R1 outputs", {26'd0, hard_irq, user_mode, exl_mode, erl_mode, debug_mode, tlb_flush}, 32'h0);

        // Table: write then read back
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][71:67], VEC[i][66:64], VEC[i][63:32]);
            rd(VEC[i][71:67], VEC[i][66:64], v);
            check($sformatf("R%0d table[%0d]", VEC[i][75:72], i), v, VEC[i][31:0]);
        end

        // R10 clear software bits; then same-cycle line rise and IE write
        wr(5'd13, 3'd0, 32'h0);
        rd(5'd13, 3'd0, v); check("R10 cause cleared", v, 32'h0);
        @(negedge clk);
        hw_irq = 6'b000001;
        wr_en = 1'b1; wr_reg = 5'd12; wr_sel = 3'd0; wr_data = 32'h0000_0401;
        @(negedge clk);
        wr_en = 1'b0;
        check("R10 collision irq uses old cause", {31'd0, hard_irq}, 32'h0);
        rd(5'd13, 3'd0, v); check("R10 cause captures line", v, 32'h0000_0400);

        // R8 set, R9 hold and clear
        wr(5'd12, 3'd0, 32'h0000_0400);
        wr(5'd12, 3'd0, 32'h0000_0401);
        check("R8 irq set", {31'd0, hard_irq}, 32'h1);
        wr(5'd12, 3'd0, 32'h0000_0401);
        check("R9 irq held", {31'd0, hard_irq}, 32'h1);
        wr(5'd12, 3'd0, 32'h0000_0400);
        check("R9 irq cleared", {31'd0, hard_irq}, 32'h0);

        // R8 blocked by exception level
        wr(5'd12, 3'd0, 32'h0000_0403);
        check("R8 exl blocks", {30'd0, hard_irq, exl_mode}, 32'h1);
        wr(5'd12, 3'd0, 32'h0000_0400);

        // R8 software interrupt bit through Cause
        hw_irq = '0;
        @(negedge clk);
        wr(5'd13, 3'd0, 32'hFFFF_FDFF);
        rd(5'd13, 3'd0, v); check("R10 cause sw only", v, 32'h0000_0100);
        wr(5'd12, 3'd0, 32'h0000_0101);
        check("R8 sw irq set", {31'd0, hard_irq}, 32'h1);
        wr(5'd12, 3'd0, 32'h0000_0000);
        check("R9 sw irq cleared", {31'd0, hard_irq}, 32'h0);

        // R11 debug flag, and R8 blocked by debug mode
        wr(5'd23, 3'd0, 32'h4000_0000);
        rd(5'd23, 3'd0, v); check("R11 debug read", v, 32'h4000_0000);
        wr(5'd12, 3'd0, 32'h0000_0101);
        check("R8 debug blocks", {31'd0, hard_irq}, 32'h0);
        wr(5'd12, 3'd0, 32'h0000_0000);
        wr(5'd23, 3'd0, 32'hFFFF_FFFF);
        rd(5'd23, 3'd0, v); check("R11 debug mask", v, 32'h5330_0120);
        wr(5'd23, 3'd0, 32'h0);
        rd(5'd23, 3'd0, v); check("R11 debug cleared", v, 32'h0);
        check("R11 debug flag low", {31'd0, debug_mode}, 32'h0);

        // R7 flags and R11 status readback
        wr(5'd12, 3'd0, 32'h0000_0016);
        check("R7 flags", {29'd0, user_mode, erl_mode, exl_mode}, 32'h7);
        rd(5'd12, 3'd0, v); check("R11 status ors um", v, 32'h0000_0010);
        wr(5'd12, 3'd0, 32'hFFFF_FFFF);
        rd(5'd12, 3'd0, v); check("R7 status mask", v, 32'hFA78_FF11);
        check("R8 exl+erl block", {31'd0, hard_irq}, 32'h0);
        wr(5'd12, 3'd0, 32'h0);
        check("R7 flags cleared", {29'd0, user_mode, erl_mode, exl_mode}, 32'h0);

        // R6 flush pulse
        wr(5'd10, 3'd0, 32'h0000_2011);
        check("R6 flush pulse", {31'd0, tlb_flush}, 32'h1);
        @(negedge clk);
        check("R6 flush one cycle", {31'd0, tlb_flush}, 32'h0);
        wr(5'd10, 3'd0, 32'h0000_4011);
        check("R6 same asid no flush", {31'd0, tlb_flush}, 32'h0);
        rd(5'd10, 3'd0, v); check("R6 entryhi", v, 32'h0000_4011);

        // R2 invalid selects
        wr(5'd14, 3'd1, 32'h1111_1111);
        rd(5'd14, 3'd0, v); check("R2 epc untouched", v, 32'hDEAD_BEEF);
        rd(5'd14, 3'd2, v); check("R2 bad sel reads zero", v, 32'h0);
        wr(5'd12, 3'd1, 32'h0000_0016);
        check("R2 status bad sel", {29'd0, user_mode, erl_mode, exl_mode}, 32'h0);

        // R13 constants, random and unimplemented numbers
        rd(5'd7, 3'd0, v); check("R13 unimplemented 7", v, 32'h0);
        rd(5'd20, 3'd0, v); check("R13 unimplemented 20", v, 32'h0);
        random_idx = 4'hA;
        rd(5'd1, 3'd0, v); check("R13 random", v, 32'h0000_000A);
        wr(5'd15, 3'd0, 32'h0);
        rd(5'd15, 3'd0, v); check("R13 prid", v, PRID_E);
        wr(5'd16, 3'd1, 32'h0);
        rd(5'd16, 3'd1, v); check("R13 config1", v, CFG1_E);
        rd(5'd16, 3'd0, v); check("R14 config after sel1 write", v, 32'h8000_8083);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule